// File: doc/BRIEF.md
# Dual-Mode Parallel Bus Register Slave

This block lets an external 8-bit microprocessor read and write a 128-entry, 8-bit register file that lives inside the chip. Two static strap inputs set the bus style. The first picks the strobe convention: either separate active-low read and write strobes, or one active-low data strobe plus a direction line. The second picks the addressing scheme: either a shared address/data bus whose address is captured when the address-latch enable falls, or separate address and data buses. An access only happens when both active-low chip selects are low.

All bus pins pass through two-flop synchronizers into the internal clock domain. A small phase machine tracks each access and raises a ready handshake a fixed two internal cycles after it sees an active strobe. It releases ready once the strobe goes inactive. For a read, the output data is loaded before ready rises. For a write, the data is committed once, on the clock edge after ready rises. The open-drain interrupt is modelled as a pull-low enable that follows a single internal request line.

Top module: `upbus_slave`

## Requirements
- R1: While reset is held, and right after it is released, `rdy`, `ad_oe` and `irq_pull` are all 0.
- R2: An access takes place only when both `cs_a_n` and `cs_b_n` are low. If either one is high, a strobe produces no `rdy`, does not drive `ad_oe`, and leaves the register file unchanged.
- R3: With `mode_ds` = 0, `rd_ds_n` low requests a read and `wr_rw` low requests a write.
- R4: With `mode_ds` = 1, `rd_ds_n` low qualifies the access. `wr_rw` high makes it a read and `wr_rw` low makes it a write.
- R5: With `mode_demux` = 0, the register address is `ad_in[6:0]` as sampled when `ale` falls. `ad_in[7]` and `addr_in` have no effect on which register is accessed.
- R6: With `mode_demux` = 1, the register address is `addr_in[6:0]`, and `ad_in` carries data only.
- R7: `ad_oe` is 1 only during a selected read while its strobe is active. It stays 0 throughout writes and while the bus is idle.
- R8: `rdy` rises exactly 5 clock edges after the strobe and chip-select pins go active: 2 synchronizer edges, 1 detect edge and 2 wait edges. During a read, `ad_out` already holds the addressed register when `rdy` rises. `rdy` falls by the 3rd clock edge after the strobe goes inactive.
- R9: A write stores `ad_in` into the addressed register exactly once per strobe assertion, on the clock edge after `rdy` rises.
- R10: `irq_pull` equals `irq_req` as it was one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ds | input | 1 | Strobe strap: 0 = separate read/write strobes, 1 = data strobe plus direction |
| mode_demux | input | 1 | Address strap: 0 = shared address/data bus, 1 = separate address bus |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| addr_in | input | 7 | Address bus (used only in separate-bus mode) |
| ad_in | input | 8 | Address/data bus as seen at the input side |
| ad_out | output | 8 | Read data driven onto the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ale | input | 1 | Address latch enable (shared-bus mode) |
| rd_ds_n | input | 1 | Read strobe, or data strobe, active low |
| wr_rw | input | 1 | Write strobe (active low), or direction (1 = read) |
| irq_req | input | 1 | Internal interrupt request |
| irq_pull | output | 1 | Pull-low enable for the open-drain interrupt pin |
| rdy | output | 1 | Ready handshake |

## Verification
A wrong phase state shows up first as a shift in when `rdy` rises. Any such shift is caught the moment `rdy` does not appear exactly 5 edges after the strobe. A wrong latched address, or a wrong captured direction, only becomes visible later, on a subsequent read. That read returns a scoreboard mismatch at its `rdy` edge, so every write is followed by readbacks under each strap combination. A missing or doubled commit shows up either as a stale readback or as a write enable held for two cycles. A stuck output enable is visible on `ad_oe` within three edges of the strobe being released.

// File: rtl/upbus_pkg.sv
package upbus_pkg;

    // Access phase, advanced once per internal clock
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT1 = 2'd1,
        PH_WAIT2 = 2'd2,
        PH_READY = 2'd3
    } phase_e;

    // Order of the synchronized pin bundle (low to high, above data and address)
    localparam int CTRL_W = 5;

endpackage

// File: rtl/upbus_sync.sv
module upbus_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/upbus_decode.sv
module upbus_decode (
    input  logic mode_ds,
    input  logic cs_a_n,
    input  logic cs_b_n,
    input  logic rd_ds_n,
    input  logic wr_rw,
    output logic active,
    output logic is_read
);

    logic chosen;

    always_comb begin
        chosen = !cs_a_n && !cs_b_n;
        if (mode_ds) begin
            active  = chosen && !rd_ds_n;
            is_read = wr_rw;
        end else begin
            active  = chosen && (!rd_ds_n || !wr_rw);
            is_read = !rd_ds_n;
        end
    end

endmodule

// File: rtl/upbus_regfile.sv
module upbus_regfile #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/upbus_slave.sv
module upbus_slave
    import upbus_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ds,
    input  logic              mode_demux,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [AW-1:0]     addr_in,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic              ale,
    input  logic              rd_ds_n,
    input  logic              wr_rw,
    input  logic              irq_req,
    output logic              irq_pull,
    output logic              rdy
);

    localparam int BUS_W = CTRL_W + AW + DATA_W;
    localparam logic [BUS_W-1:0] BUS_RST = {4'b1111, 1'b0, {(AW + DATA_W){1'b0}}};

    typedef struct packed {
        phase_e            phase;
        logic [AW-1:0]     addr_lat;
        logic [AW-1:0]     addr_acc;
        logic              is_rd;
        logic              done;
        logic              rdy;
        logic              oe;
        logic [DATA_W-1:0] dout;
        logic              irq;
        logic              ale_prev;
    } state_t;

    state_t st_d, st_q;

    // synchronized pins
    logic [BUS_W-1:0]  bus_raw, bus_s;
    logic              s_cs_a_n, s_cs_b_n, s_rd_ds_n, s_wr_rw, s_ale;
    logic [AW-1:0]     s_addr;
    logic [DATA_W-1:0] s_ad;
    logic              s_act, s_read;

    // register file port
    logic              rf_we;
    logic [DATA_W-1:0] rf_rdata;
    logic [AW-1:0]     cur_addr;

    assign bus_raw = {cs_a_n, cs_b_n, rd_ds_n, wr_rw, ale, addr_in, ad_in};

    upbus_sync #(
        .W      (BUS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(BUS_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (bus_raw),
        .q    (bus_s)
    );

    assign {s_cs_a_n, s_cs_b_n, s_rd_ds_n, s_wr_rw, s_ale, s_addr, s_ad} = bus_s;

    upbus_decode u_dec (
        .mode_ds(mode_ds),
        .cs_a_n (s_cs_a_n),
        .cs_b_n (s_cs_b_n),
        .rd_ds_n(s_rd_ds_n),
        .wr_rw  (s_wr_rw),
        .active (s_act),
        .is_read(s_read)
    );

    upbus_regfile #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W)
    ) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (rf_we),
        .waddr(st_q.addr_acc),
        .wdata(s_ad),
        .raddr(st_q.addr_acc),
        .rdata(rf_rdata)
    );

    // next-state logic
    always_comb begin
        st_d          = st_q;
        rf_we         = 1'b0;
        st_d.irq      = irq_req;
        st_d.ale_prev = s_ale;

        // address capture on falling edge of synchronized ALE (shared bus only)
        if (!mode_demux && st_q.ale_prev && !s_ale) begin
            st_d.addr_lat = s_ad[AW-1:0];
        end
        cur_addr = mode_demux ? s_addr : st_q.addr_lat;

        if (st_q.phase != PH_IDLE && !s_act) begin
            st_d.phase = PH_IDLE;
            st_d.rdy   = 1'b0;
            st_d.oe    = 1'b0;
            st_d.done  = 1'b0;
        end else begin
            case (st_q.phase)
                PH_IDLE: begin
                    st_d.rdy  = 1'b0;
                    st_d.oe   = 1'b0;
                    st_d.done = 1'b0;
                    if (s_act) begin
                        st_d.phase    = PH_WAIT1;
                        st_d.addr_acc = cur_addr;
                        st_d.is_rd    = s_read;
                        st_d.oe       = s_read;
                    end
                end
                PH_WAIT1: begin
                    st_d.dout  = rf_rdata;
                    st_d.phase = PH_WAIT2;
                end
                PH_WAIT2: begin
                    st_d.phase = PH_READY;
                    st_d.rdy   = 1'b1;
                end
                PH_READY: begin
                    if (!st_q.is_rd && !st_q.done) begin
                        rf_we     = 1'b1;
                        st_d.done = 1'b1;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.phase    <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy      = st_q.rdy;
    assign ad_oe    = st_q.oe;
    assign ad_out   = st_q.dout;
    assign irq_pull = st_q.irq;

endmodule

// File: rtl/upbus_slave_chk.sv
module upbus_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              irq_pull,
    input logic              rdy,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic              we,
    input logic              act
);

    p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> irq_pull);

    p_irq_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |=> !irq_pull);

    p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    p_commit_after_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> rdy);

    p_rdy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !act) |=> !rdy);

    p_read_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && ad_oe && act) |=> $stable(ad_out));

    p_oe_before_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> !rdy);

    p_oe_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !act) |=> !ad_oe);

endmodule

bind upbus_slave upbus_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .irq_pull(irq_pull),
    .rdy     (rdy),
    .ad_oe   (ad_oe),
    .ad_out  (ad_out),
    .we      (rf_we),
    .act     (s_act)
);

// File: tb/sim_upbus_slave.sv
`timescale 1ns/1ps
module sim_upbus_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ds = 1'b0, mode_demux = 1'b1;
    logic       cs_a_n = 1'b1, cs_b_n = 1'b1;
    logic [6:0] addr_in = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe, ale = 1'b0, rd_ds_n = 1'b1, wr_rw = 1'b1;
    logic       irq_req = 1'b0, irq_pull, rdy;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] model [128];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         mon_read = 1'b0;
    logic       rdy_prev = 1'b0;

    always #4 clk = ~clk;

    upbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .mode_ds(mode_ds), .mode_demux(mode_demux),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .addr_in(addr_in), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_ds_n(rd_ds_n),
        .wr_rw(wr_rw), .irq_req(irq_req), .irq_pull(irq_pull), .rdy(rdy)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: pops expected read data when ready rises
    always @(negedge clk) begin
        if (rdy && !rdy_prev && mon_read) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected read", ad_out, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(ad_out === e, t, ad_out, e);
                check(ad_oe === 1'b1, "R7 oe during read", ad_oe, 1);
            end
        end
        rdy_prev = rdy;
    end

    // one bus access; sel_ok=0 leaves chip select B high
    task automatic access(input bit rd, input logic [6:0] a, input logic [7:0] d,
                          input bit sel_ok, input string req);
        int lat;
        if (!mode_demux) begin
            ad_in   = {1'b1, a};
            addr_in = ~a;
            ale     = 1'b1;
            repeat (3) @(negedge clk);
            ale = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            addr_in = a;
        end
        ad_in    = rd ? 8'h00 : d;
        mon_read = rd;
        if (rd && sel_ok) begin
            exp_q.push_back(model[a]);
            tag_q.push_back(req);
        end
        cs_a_n = 1'b0;
        cs_b_n = !sel_ok;
        if (mode_ds) begin
            wr_rw   = rd;
            rd_ds_n = 1'b0;
        end else if (rd) begin
            rd_ds_n = 1'b0;
        end else begin
            wr_rw = 1'b0;
        end
        if (!sel_ok) begin
            repeat (10) @(negedge clk);
            check(rdy === 1'b0, "R2 rdy while deselected", rdy, 0);
            check(ad_oe === 1'b0, "R2 oe while deselected", ad_oe, 0);
        end else begin
            lat = 0;
            do begin
                @(negedge clk);
                lat++;
            end while (!rdy && lat < 20);
            check(lat == 5, "R8 ready latency", lat, 5);
            if (!rd) check(ad_oe === 1'b0, "R7 oe during write", ad_oe, 0);
            repeat (2) @(negedge clk);
            if (!rd) model[a] = d;
        end
        rd_ds_n = 1'b1;
        wr_rw   = 1'b1;
        repeat (3) @(negedge clk);
        check(rdy === 1'b0, "R8 ready release", rdy, 0);
        check(ad_oe === 1'b0, "R7 oe after strobe", ad_oe, 0);
        cs_a_n   = 1'b1;
        cs_b_n   = 1'b1;
        mon_read = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #800000;
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(rdy === 1'b0 && ad_oe === 1'b0 && irq_pull === 1'b0, "R1 in reset",
              {rdy, ad_oe, irq_pull}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rdy === 1'b0 && ad_oe === 1'b0 && irq_pull === 1'b0, "R1 after reset",
              {rdy, ad_oe, irq_pull}, 0);

        // R3 + R6: separate strobes, separate address bus
        mode_ds = 1'b0; mode_demux = 1'b1;
        access(0, 7'h05, 8'hA5, 1, "R3 write");
        access(0, 7'h7F, 8'h3C, 1, "R6 write top address");
        access(1, 7'h05, 8'h00, 1, "R3 R6 read 05");
        access(1, 7'h7F, 8'h00, 1, "R6 read 7F");

        // R4: data strobe with direction line
        mode_ds = 1'b1;
        access(0, 7'h10, 8'h5A, 1, "R4 write");
        access(1, 7'h10, 8'h00, 1, "R4 read 10");
        access(1, 7'h05, 8'h00, 1, "R4 read 05");

        // R5: shared address/data bus, AD7 set and addr_in inverted
        mode_ds = 1'b0; mode_demux = 1'b0;
        access(0, 7'h22, 8'hC3, 1, "R5 write");
        access(1, 7'h22, 8'h00, 1, "R5 read 22");
        access(1, 7'h10, 8'h00, 1, "R5 read 10");
        mode_ds = 1'b1;
        access(0, 7'h41, 8'h99, 1, "R5 R4 write");
        access(1, 7'h41, 8'h00, 1, "R5 R4 read 41");
        access(0, 7'h41, 8'h17, 1, "R9 overwrite");
        access(1, 7'h41, 8'h00, 1, "R9 read after overwrite");

        // R2: one chip select high blocks the write
        mode_ds = 1'b0; mode_demux = 1'b1;
        access(0, 7'h05, 8'h00, 0, "R2 deselected write");
        access(1, 7'h05, 8'h00, 1, "R2 value kept");

        // R10: interrupt pull follows request
        irq_req = 1'b1;
        @(negedge clk);
        check(irq_pull === 1'b1, "R10 assert", irq_pull, 1);
        irq_req = 1'b0;
        @(negedge clk);
        check(irq_pull === 1'b0, "R10 release", irq_pull, 0);

        check(exp_q.size() == 0, "R8 reads left unanswered", exp_q.size(), 0);
        finish_run();
    end

endmodule